// File: doc/BRIEF.md
# Synchronous Burst SRAM with Byte-Lane Writes

This block is a small on-chip synchronous SRAM. Commands are registered, but the read path is not. A word is made of four 9-bit byte lanes (8 data bits plus 1 parity bit each), and the depth is set by a parameter. The address, the strobes, the advance input, the write controls and the write data are all sampled on the rising clock edge. The word selected by the registered address flows straight from the array to `rdata_o` in the cycle that follows that edge.

A single presented address produces a burst of four word accesses. An internal two-bit beat counter changes the low two address bits on every edge where advance is held low. The upper address bits do not change during a burst. The mode input picks the order of the low bits: in linear order they count up modulo 4, and in interleaved order they are the loaded bits XORed with the beat number.

Either of two address strobes starts a burst. The processor strobe is honoured only while chip enable is active. The controller strobe is always honoured, so it can restart a burst at any point. A strobe taken while the chip is not selected deselects the device on the next cycle. The sleep input stops all activity at once and keeps the stored contents. The output enable gates the output drivers without waiting for a clock edge.

The control FSM has four states:
- `ST_IDLE`: deselected.
- `ST_RD`: read access active.
- `ST_WR`: write access active.
- `ST_SLEEP`: power-down.

Its transitions are:
- **start**: a strobe with the chip selected moves IDLE or SLEEP to RD or WR.
- **continue**: no strobe while active; the state stays RD or WR, and the write controls pick which.
- **restart**: a strobe with the chip selected while active reloads the burst.
- **deselect**: a strobe with the chip not selected moves to IDLE.
- **doze**: sleep high moves any state to SLEEP.
- **wake**: SLEEP with sleep low behaves exactly like IDLE.

Top module: `sbsram_core`

## Requirements
- R1: After an edge that starts or continues a read while `oe_n_i` is low, `dq_oe_o` is 1 and `rdata_o` equals the stored word at the registered address in the cycle that follows that edge.
- R2: With `lbo_n_i` = 0 (linear order), each edge with `adv_n_i` low and no strobe moves the low two address bits to loaded+1, +2 and +3 modulo 4. The upper bits are left unchanged.
- R3: With `lbo_n_i` = 1 (interleaved order), the low two address bits of beat k (k = 0..3) equal the loaded bits XOR k.
- R4: While active with no strobe, an edge with `adv_n_i` high repeats the access at the same address.
- R5: `adsp_n_i` low loads a new address only when `ce_n_i` is low. With `ce_n_i` high the processor strobe is ignored and an active burst goes on.
- R6: `adsc_n_i` low always loads `addr_i` as the new burst start, including in the middle of a burst.
- R7: `gw_n_i` low writes all four lanes of the beat's word, whatever `bwe_n_i` and `bw_n_i` are.
- R8: With `gw_n_i` high, lane i (bits 9i+8..9i) is written only when `bwe_n_i` is low and `bw_n_i[i]` is low; the other lanes keep their contents. With `bwe_n_i` high and `gw_n_i` high, the cycle is a read.
- R9: A write beat stores `wdata_i` at that beat's address on the edge, and `dq_oe_o` stays 0 during the following cycle.
- R10: A strobe taken while `ce_n_i`, `cs_a_n_i` or `cs_b_n_i` is high writes nothing and leaves `dq_oe_o` at 0 from the next cycle on.
- R11: `oe_n_i` high forces `dq_oe_o` to 0 at once, without waiting for an edge.
- R12: While `sleep_i` is high, `dq_oe_o` is 0 at once and every access is ignored, with contents kept. The first edge after `sleep_i` falls processes commands normally.
- R13: While `rst_n` is low, and after reset until the first start, `dq_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| sleep_i | input | 1 | Power-down request, active high, asynchronous |
| ce_n_i | input | 1 | Chip enable, active low |
| cs_a_n_i | input | 1 | Chip select A, active low |
| cs_b_n_i | input | 1 | Chip select B, active low |
| adsp_n_i | input | 1 | Processor address strobe, active low |
| adsc_n_i | input | 1 | Controller address strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| lbo_n_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| gw_n_i | input | 1 | Global write, active low |
| bwe_n_i | input | 1 | Byte write enable, active low |
| bw_n_i | input | LANES | Per-lane write selects, active low |
| oe_n_i | input | 1 | Output enable, active low, asynchronous |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | LANES*LANE_W | Write data |
| rdata_o | output | LANES*LANE_W | Read data, zero while not driven |
| dq_oe_o | output | 1 | Output drive enable |

## Verification
The embedded properties check these on every cycle:
- The output is quiet under sleep, a high output enable and a write state.
- Deselect takes effect one cycle after a strobe with the chip not selected.
- The global-write and no-enable lane decodes are correct.
- The low address bits hold or step by one in linear order.

Only the bench's scenarios can show that the right data reaches the right word:
- interleaved address sequences;
- partial-lane merges;
- restarts by the controller strobe;
- processor strobes that are ignored;
- contents surviving sleep and deselected write attempts.

The bench shows these by comparing read data with a reference memory.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RD    = 2'd1,
        ST_WR    = 2'd2,
        ST_SLEEP = 2'd3
    } sb_state_e;

    // Low two address bits for a given beat of a burst.
    function automatic logic [1:0] burst_lo(input logic [1:0] base,
                                            input logic [1:0] beat,
                                            input logic       linear);
        return linear ? (base + beat) : (base ^ beat);
    endfunction

endpackage

// File: rtl/sbsram_burst_ctr.sv
module sbsram_burst_ctr
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              adv_i,
    input  logic              linear_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] cur_addr_o,
    output logic [ADDR_W-1:0] nxt_addr_o
);
    localparam int HI_W = ADDR_W - 2;

    logic [HI_W-1:0] hi_q, hi_d;
    logic [1:0]      lo0_q, lo0_d;
    logic [1:0]      cnt_q, cnt_d;

    always_comb begin
        hi_d  = hi_q;
        lo0_d = lo0_q;
        cnt_d = cnt_q;
        if (load_i) begin
            hi_d  = addr_i[ADDR_W-1:2];
            lo0_d = addr_i[1:0];
            cnt_d = 2'd0;
        end else if (adv_i) begin
            cnt_d = cnt_q + 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q  <= '0;
            lo0_q <= '0;
            cnt_q <= '0;
        end else begin
            hi_q  <= hi_d;
            lo0_q <= lo0_d;
            cnt_q <= cnt_d;
        end
    end

    assign cur_addr_o = {hi_q, burst_lo(lo0_q, cnt_q, linear_i)};
    assign nxt_addr_o = {hi_d, burst_lo(lo0_d, cnt_d, linear_i)};

    // R4
    hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !adv_i) |=> (cur_addr_o == $past(cur_addr_o) || linear_i != $past(linear_i)));

    // R2
    lin_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && adv_i && linear_i) |=>
            (!linear_i || (cur_addr_o[1:0] == $past(cur_addr_o[1:0]) + 2'd1
                           && cur_addr_o[ADDR_W-1:2] == $past(cur_addr_o[ADDR_W-1:2]))));

endmodule

// File: rtl/sbsram_lane_wen.sv
module sbsram_lane_wen #(
    parameter int LANES = 4
) (
    input  logic             gw_n_i,
    input  logic             bwe_n_i,
    input  logic [LANES-1:0] bw_n_i,
    output logic [LANES-1:0] lane_req_o
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_req_o[g] = !gw_n_i || (!bwe_n_i && !bw_n_i[g]);
    end
endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        lane_we_i,
    input  logic [ADDR_W-1:0]       waddr_i,
    input  logic [LANES*LANE_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0]       raddr_i,
    output logic [LANES*LANE_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (lane_we_i[g]) begin
                mem[waddr_i] <= wdata_i[g*LANE_W +: LANE_W];
            end
        end

        assign rdata_o[g*LANE_W +: LANE_W] = mem[raddr_i];
    end
endmodule

// File: rtl/sbsram_core.sv
module sbsram_core
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sleep_i,
    input  logic                    ce_n_i,
    input  logic                    cs_a_n_i,
    input  logic                    cs_b_n_i,
    input  logic                    adsp_n_i,
    input  logic                    adsc_n_i,
    input  logic                    adv_n_i,
    input  logic                    lbo_n_i,
    input  logic                    gw_n_i,
    input  logic                    bwe_n_i,
    input  logic [LANES-1:0]        bw_n_i,
    input  logic                    oe_n_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [LANES*LANE_W-1:0] wdata_i,
    output logic [LANES*LANE_W-1:0] rdata_o,
    output logic                    dq_oe_o
);
    localparam int DATA_W = LANES * LANE_W;

    sb_state_e          state_q, state_d;
    logic               sel, strobe, active, wr_req, load, adv;
    logic [LANES-1:0]   lane_req, lane_we;
    logic [ADDR_W-1:0]  cur_addr, nxt_addr;
    logic [DATA_W-1:0]  arr_rdata;

    assign sel    = !ce_n_i && !cs_a_n_i && !cs_b_n_i;
    assign strobe = (!adsp_n_i && !ce_n_i) || !adsc_n_i;
    assign active = (state_q == ST_RD) || (state_q == ST_WR);
    assign wr_req = |lane_req;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        if (sleep_i) begin
            state_d = ST_SLEEP;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_SLEEP: begin
                    if (strobe && sel) state_d = wr_req ? ST_WR : ST_RD;
                    else               state_d = ST_IDLE;
                end
                ST_RD, ST_WR: begin
                    if (strobe && !sel) state_d = ST_IDLE;
                    else                state_d = wr_req ? ST_WR : ST_RD;
                end
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign load    = !sleep_i && strobe && sel;
    assign adv     = !sleep_i && !strobe && active && !adv_n_i;
    assign lane_we = (state_d == ST_WR) ? lane_req : '0;

    // Output logic: flow-through, gated asynchronously.
    always_comb begin
        dq_oe_o = (state_q == ST_RD) && !oe_n_i && !sleep_i;
        rdata_o = dq_oe_o ? arr_rdata : '0;
    end

    sbsram_burst_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .adv_i      (adv),
        .linear_i   (!lbo_n_i),
        .addr_i     (addr_i),
        .cur_addr_o (cur_addr),
        .nxt_addr_o (nxt_addr)
    );

    sbsram_lane_wen #(.LANES(LANES)) u_wen (
        .gw_n_i     (gw_n_i),
        .bwe_n_i    (bwe_n_i),
        .bw_n_i     (bw_n_i),
        .lane_req_o (lane_req)
    );

    sbsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
        .clk       (clk),
        .lane_we_i (lane_we),
        .waddr_i   (nxt_addr),
        .wdata_i   (wdata_i),
        .raddr_i   (cur_addr),
        .rdata_o   (arr_rdata)
    );

    // R12
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |-> (!dq_oe_o && lane_we == '0));

    // R11
    oe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n_i |-> !dq_oe_o);

    // R10
    desel_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_i && !adsc_n_i && !sel) |=> (!dq_oe_o && $past(lane_we) == '0));

    // R7
    gw_all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gw_n_i |-> (&lane_req));

    // R8
    no_enable_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gw_n_i && bwe_n_i) |-> (lane_we == '0));

    // R9
    write_hides_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WR) |-> !dq_oe_o);

endmodule

// File: tb/sbsram_core_tb_top.sv
`timescale 1ns/1ps
module sbsram_core_tb_top;
    localparam int AW = 6;
    localparam int NL = 4;
    localparam int LW = 9;
    localparam int DW = NL * LW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_i = 1'b0;
    logic ce_n = 1'b0, cs_a_n = 1'b0, cs_b_n = 1'b0;
    logic adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1, lbo_n = 1'b0;
    logic gw_n = 1'b1, bwe_n = 1'b1, oe_n = 1'b0;
    logic [NL-1:0] bw_n = '1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          dq_oe;

    logic [DW-1:0] mdl [1<<AW];
    int checks = 0;
    int errors = 0;

    sbsram_core #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) dut_i (
        .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .ce_n_i(ce_n),
        .cs_a_n_i(cs_a_n), .cs_b_n_i(cs_b_n), .adsp_n_i(adsp_n),
        .adsc_n_i(adsc_n), .adv_n_i(adv_n), .lbo_n_i(lbo_n), .gw_n_i(gw_n),
        .bwe_n_i(bwe_n), .bw_n_i(bw_n), .oe_n_i(oe_n), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .dq_oe_o(dq_oe)
    );

    always #4 clk = ~clk;

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] base, input int beat, input bit lin);
        logic [1:0] b = 2'(beat);
        return {base[AW-1:2], lin ? (base[1:0] + b) : (base[1:0] ^ b)};
    endfunction

    function automatic void mdl_write(input logic [AW-1:0] a, input bit gw, input bit bwe,
                                      input logic [NL-1:0] bwn, input logic [DW-1:0] d);
        for (int i = 0; i < NL; i++)
            if (gw || (bwe && !bwn[i])) mdl[a][i*LW +: LW] = d[i*LW +: LW];
    endfunction

    task automatic idle_inputs();
        adsp_n = 1'b1; adsc_n = 1'b1; adv_n = 1'b1;
        gw_n = 1'b1; bwe_n = 1'b1; bw_n = '1;
    endtask

    task automatic run_burst(input logic [AW-1:0] base, input bit lin, input bit use_adsp,
                             input bit gw, input bit bwe, input logic [NL-1:0] bwn, input int beats);
        for (int k = 0; k < beats; k++) begin
            logic [AW-1:0] a;
            bit wr;
            lbo_n = !lin;
            if (k == 0) begin
                addr = base; adsp_n = !use_adsp; adsc_n = use_adsp; adv_n = 1'b1;
            end else begin
                addr = AW'($urandom); adsp_n = 1'b1; adsc_n = 1'b1; adv_n = 1'b0;
            end
            gw_n = !gw; bwe_n = !bwe; bw_n = bwn;
            wdata = {4'($urandom), $urandom};
            step();
            a  = exp_addr(base, k, lin);
            wr = gw || (bwe && bwn != '1);
            if (wr) begin
                mdl_write(a, gw, bwe, bwn, wdata);
                check("R9 write beat hides output", 64'(dq_oe), 64'd0);
            end else begin
                check("R1 read drive", 64'(dq_oe), 64'd1);
                check(k == 0 ? (use_adsp ? "R5 adsp load" : "R1 read data")
                             : (lin ? "R2 linear beat" : "R3 interleaved beat"),
                      64'(rdata), 64'(mdl[a]));
            end
        end
        idle_inputs();
    endtask

    task automatic write1(input logic [AW-1:0] a, input bit gw, input bit bwe,
                          input logic [NL-1:0] bwn, input logic [DW-1:0] d);
        addr = a; adsc_n = 1'b0; gw_n = !gw; bwe_n = !bwe; bw_n = bwn; wdata = d;
        step();
        mdl_write(a, gw, bwe, bwn, d);
        idle_inputs();
    endtask

    task automatic read1(input logic [AW-1:0] a, input string req);
        addr = a; adsc_n = 1'b0;
        step();
        check(req, 64'(dq_oe), 64'd1);
        check(req, 64'(rdata), 64'(mdl[a]));
        idle_inputs();
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'h5A17);
        #2;
        // R13 reset state
        repeat (3) step();
        check("R13 out off in reset", 64'(dq_oe), 64'd0);
        rst_n = 1'b1;
        step();
        check("R13 out off after reset", 64'(dq_oe), 64'd0);

        // Fill memory with global-write linear bursts (R7, R9).
        for (int b = 0; b < (1 << AW) / 4; b++)
            run_burst(AW'(b * 4), 1'b1, 1'b0, 1'b1, 1'b0, '1, 4);
        for (int a = 0; a < 4; a++) read1(AW'(a), "R7 global write readback");

        // R4 suspend
        run_burst(6'd5, 1'b1, 1'b0, 1'b0, 1'b0, '1, 2);
        step();
        check("R4 suspend same address", 64'(rdata), 64'(mdl[6]));
        adv_n = 1'b0;
        step();
        check("R4 advance after suspend", 64'(rdata), 64'(mdl[7]));
        idle_inputs();

        // R5 processor strobe ignored with chip enable high
        run_burst(6'd8, 1'b1, 1'b0, 1'b0, 1'b0, '1, 2);
        ce_n = 1'b1; adsp_n = 1'b0; addr = 6'd40; adv_n = 1'b0;
        step();
        check("R5 adsp ignored drive", 64'(dq_oe), 64'd1);
        check("R5 adsp ignored data", 64'(rdata), 64'(mdl[10]));
        ce_n = 1'b0; idle_inputs();

        // R6 controller strobe restart mid-burst, interleaved
        run_burst(6'd12, 1'b0, 1'b0, 1'b0, 1'b0, '1, 2);
        adsc_n = 1'b0; addr = 6'd33;
        step();
        check("R6 restart address", 64'(rdata), 64'(mdl[33]));
        adsc_n = 1'b1; adv_n = 1'b0;
        step();
        check("R6 R3 interleaved after restart", 64'(rdata), 64'(mdl[32]));
        idle_inputs();

        // R8 byte lanes 0 and 2 only
        write1(6'd20, 1'b0, 1'b1, 4'b1010, 36'hA_BCDE_F123);
        read1(6'd20, "R8 partial lanes");
        write1(6'd20, 1'b0, 1'b0, 4'b0000, 36'h5_5555_5555);
        check("R8 no enable is read", 64'(dq_oe), 64'd1);
        check("R8 no enable keeps data", 64'(rdata), 64'(mdl[20]));
        // R7 global write overrides lane selects
        write1(6'd21, 1'b1, 1'b0, 4'b1111, 36'h1_2345_6789);
        read1(6'd21, "R7 global write all lanes");

        // R11 asynchronous output enable
        read1(6'd22, "R11 setup read");
        oe_n = 1'b1; #1;
        check("R11 oe high off", 64'(dq_oe), 64'd0);
        oe_n = 1'b0; #1;
        check("R11 oe low on", 64'(dq_oe), 64'd1);

        // R12 sleep
        read1(6'd3, "R12 setup read");
        sleep_i = 1'b1; #1;
        check("R12 sleep output off", 64'(dq_oe), 64'd0);
        addr = 6'd3; adsc_n = 1'b0; gw_n = 1'b0; wdata = 36'hF_FFFF_FFFF;
        step(); step();
        check("R12 asleep off", 64'(dq_oe), 64'd0);
        sleep_i = 1'b0; gw_n = 1'b1;
        step();
        check("R12 wake drive", 64'(dq_oe), 64'd1);
        check("R12 contents kept", 64'(rdata), 64'(mdl[3]));
        idle_inputs();

        // R10 deselect
        read1(6'd7, "R10 setup read");
        ce_n = 1'b1; adsc_n = 1'b0; gw_n = 1'b0; addr = 6'd7; wdata = 36'h0_0000_0000;
        step();
        check("R10 ce deselect off", 64'(dq_oe), 64'd0);
        ce_n = 1'b0; idle_inputs();
        read1(6'd7, "R10 no write while deselected");
        cs_b_n = 1'b1; adsc_n = 1'b0;
        step();
        check("R10 cs_b deselect off", 64'(dq_oe), 64'd0);
        cs_b_n = 1'b0; idle_inputs();
        read1(6'd9, "R10 reselect");
        cs_a_n = 1'b1; adsp_n = 1'b0;
        step();
        check("R10 adsp with cs_a high deselects", 64'(dq_oe), 64'd0);
        cs_a_n = 1'b0; idle_inputs();

        // Random bursts
        for (int it = 0; it < 200; it++) begin
            int kind = int'($urandom % 3);
            run_burst(AW'($urandom), 1'($urandom), 1'($urandom), kind == 1, kind == 2,
                      NL'($urandom), 1 + int'($urandom % 4));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule